// File: doc/BRIEF.md
# Start-up Supply Source Sequencer

This block is the digital sequencer for an off-line high-voltage current source. The source charges the supply capacitor of a switching controller at power-up and later keeps that rail topped up whenever the auxiliary winding cannot. The block reads five comparator flags, which are already synchronised to its clock:

- input voltage high enough for the source to work;
- rail above the inhibit level;
- rail at the turn-on level;
- rail down at the restart level;
- die over temperature.

From these flags it drives a two-bit current-level select and a one-cycle pulse that lets the controller begin switching.

The source runs as a hysteretic keeper. It stops when the rail reaches the turn-on level and starts again when the rail falls back to the restart level. While the rail is below the inhibit level, for example when the rail pin is shorted, only the reduced current is allowed. Over-temperature overrides everything, and when it clears a fresh start-up follows. The first turn-on crossing only marks the end of the initial charge. The controller is released on the following crossing, after one complete top-up cycle.

Top module: `ssq_supply_keeper`

## Requirements
- R1: While `vcc_rst_n` is low, the sequencer is in its low-current charge state, `ctl_start` is 0, and all start progress is cleared. Once reset is released, the first turn-on crossing gives no start pulse.
- R2: `src_sel` is 2'b00 (off) in the same cycle that `hv_ok` is 0, whatever the internal state.
- R3: In a charge state, `src_sel` is 2'b01 (low current) when `vcc_gt_inh` was 0 at the previous clock edge and 2'b10 (full current) when it was 1. Code 2'b11 is never produced.
- R4: When `vcc_gt_on` is sampled high in a charge state, `src_sel` is 2'b00 from the next cycle on.
- R5: While stopped, `src_sel` stays 2'b00 until `vcc_lt_restart` is sampled high. It then turns on at the level R3 gives, one cycle later.
- R6: `tsd_flag` sampled high forces `src_sel` to 2'b00 from the next cycle, from any state, and holds it there while the flag stays high. When the flag is sampled low, the next cycle is in a charge state with start progress cleared.
- R7: No start is issued on the first turn-on crossing. On the second crossing, `ctl_start` is high for exactly one cycle, in the same cycle `src_sel` goes to 2'b00.
- R8: After a start has been issued, later crossings produce no further `ctl_start` until reset or over-temperature.
- R9: Low `hv_ok` only masks the source. The hysteresis state keeps advancing, so when `hv_ok` returns in a charge state the source is on again in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| vcc_rst_n | input | 1 | Asynchronous active-low reset from the rail-reset detector |
| hv_ok | input | 1 | High-voltage input above the source's minimum |
| vcc_gt_inh | input | 1 | Rail above the inhibit level |
| vcc_gt_on | input | 1 | Rail at or above the turn-on level |
| vcc_lt_restart | input | 1 | Rail at or below the restart level |
| tsd_flag | input | 1 | Thermal shutdown active |
| src_sel | output | 2 | Source level: 00 off, 01 low, 10 full |
| ctl_start | output | 1 | One-cycle controller start pulse |

## Verification
The `hv_ok` gating is combinational, so its effect on `src_sel` is due in the same cycle. Every other response goes through one state register, so `src_sel` and `ctl_start` change one clock edge after the flag that caused them is sampled. The bench changes inputs on the falling edge. For the registered results it checks at the next falling edge, after exactly one rising edge. For the `hv_ok` mask and the asynchronous reset it checks a moment after the input changes, before any rising edge.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

  typedef enum logic [1:0] {
    ST_CHG_LOW  = 2'd0,
    ST_CHG_FULL = 2'd1,
    ST_HOLD     = 2'd2,
    ST_THERM    = 2'd3
  } src_state_e;

  localparam logic [1:0] SEL_OFF  = 2'b00;
  localparam logic [1:0] SEL_LOW  = 2'b01;
  localparam logic [1:0] SEL_FULL = 2'b10;

  function automatic logic is_charging(input src_state_e s);
    return (s == ST_CHG_LOW) || (s == ST_CHG_FULL);
  endfunction

  function automatic src_state_e charge_level(input logic above_inh);
    return above_inh ? ST_CHG_FULL : ST_CHG_LOW;
  endfunction

  function automatic src_state_e next_state(
    input src_state_e s,
    input logic       above_inh,
    input logic       at_on,
    input logic       at_restart,
    input logic       therm
  );
    src_state_e n;
    n = s;
    if (therm) begin
      n = ST_THERM;
    end else begin
      case (s)
        ST_CHG_LOW, ST_CHG_FULL: n = at_on ? ST_HOLD : charge_level(above_inh);
        ST_HOLD:                 n = at_restart ? charge_level(above_inh) : ST_HOLD;
        default:                 n = charge_level(above_inh);
      endcase
    end
    return n;
  endfunction

  function automatic logic [1:0] sel_code(input src_state_e s, input logic hv);
    logic [1:0] c;
    if (!hv) c = SEL_OFF;
    else begin
      case (s)
        ST_CHG_LOW:  c = SEL_LOW;
        ST_CHG_FULL: c = SEL_FULL;
        default:     c = SEL_OFF;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/ssq_state_fsm.sv
module ssq_state_fsm
  import ssq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       above_inh,
  input  logic       at_on,
  input  logic       at_restart,
  input  logic       therm,
  output src_state_e state,
  output logic       stop_entry,
  output logic       restart_evt
);

  src_state_e state_q;
  src_state_e state_d;

  always_comb begin
    state_d = next_state(state_q, above_inh, at_on, at_restart, therm);
  end

  // Charge -> hold transition this edge: a turn-on crossing.
  assign stop_entry  = is_charging(state_q) && (state_d == ST_HOLD);
  // Hold -> charge transition this edge: a top-up begins.
  assign restart_evt = (state_q == ST_HOLD) && is_charging(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_CHG_LOW;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/ssq_start_track.sv
module ssq_start_track #(
  parameter int unsigned START_CROSSING = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic therm,
  input  logic stop_entry,
  output logic start_pulse
);

  localparam int unsigned CW = (START_CROSSING < 2) ? 1 : $clog2(START_CROSSING);
  localparam logic [CW-1:0] LAST_IDX = CW'(START_CROSSING - 1);

  logic [CW-1:0] cross_cnt;
  logic          started;
  logic          pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cross_cnt <= '0;
      started   <= 1'b0;
      pulse_q   <= 1'b0;
    end else if (therm) begin
      cross_cnt <= '0;
      started   <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (stop_entry && !started) begin
        if (cross_cnt == LAST_IDX) begin
          pulse_q <= 1'b1;
          started <= 1'b1;
        end else begin
          cross_cnt <= cross_cnt + 1'b1;
        end
      end
    end
  end

  assign start_pulse = pulse_q;

endmodule

// File: rtl/ssq_sel_drive.sv
module ssq_sel_drive
  import ssq_pkg::*;
(
  input  src_state_e state,
  input  logic       hv,
  output logic [1:0] sel
);

  always_comb begin
    sel = sel_code(state, hv);
  end

endmodule

// File: rtl/ssq_supply_keeper.sv
module ssq_supply_keeper
  import ssq_pkg::*;
#(
  parameter int unsigned START_CROSSING = 2
) (
  input  logic       clk,
  input  logic       vcc_rst_n,
  input  logic       hv_ok,
  input  logic       vcc_gt_inh,
  input  logic       vcc_gt_on,
  input  logic       vcc_lt_restart,
  input  logic       tsd_flag,
  output logic [1:0] src_sel,
  output logic       ctl_start
);

  src_state_e state;
  logic       stop_entry;
  logic       restart_evt;

  ssq_state_fsm u_fsm (
    .clk        (clk),
    .rst_n      (vcc_rst_n),
    .above_inh  (vcc_gt_inh),
    .at_on      (vcc_gt_on),
    .at_restart (vcc_lt_restart),
    .therm      (tsd_flag),
    .state      (state),
    .stop_entry (stop_entry),
    .restart_evt(restart_evt)
  );

  ssq_start_track #(.START_CROSSING(START_CROSSING)) u_start (
    .clk        (clk),
    .rst_n      (vcc_rst_n),
    .therm      (tsd_flag),
    .stop_entry (stop_entry),
    .start_pulse(ctl_start)
  );

  ssq_sel_drive u_sel (
    .state(state),
    .hv   (hv_ok),
    .sel  (src_sel)
  );

endmodule

// File: rtl/ssq_supply_keeper_chk.sv
module ssq_supply_keeper_chk (
  input logic       clk,
  input logic       vcc_rst_n,
  input logic       hv_ok,
  input logic       tsd_flag,
  input logic [1:0] src_sel,
  input logic       ctl_start,
  input logic       stop_entry,
  input logic       restart_evt
);

  logic start_seen;

  always_ff @(posedge clk or negedge vcc_rst_n) begin
    if (!vcc_rst_n)     start_seen <= 1'b0;
    else if (tsd_flag)  start_seen <= 1'b0;
    else if (ctl_start) start_seen <= 1'b1;
  end

  // R2
  hv_mask_chk: assert property (@(posedge clk) disable iff (!vcc_rst_n)
    !hv_ok |-> src_sel == 2'b00);

  // R3
  no_bad_code_chk: assert property (@(posedge clk) disable iff (!vcc_rst_n)
    src_sel != 2'b11);

  // R4
  stop_on_cross_chk: assert property (@(posedge clk) disable iff (!vcc_rst_n)
    stop_entry |=> src_sel == 2'b00);

  // R5
  restart_on_chk: assert property (@(posedge clk) disable iff (!vcc_rst_n)
    restart_evt |=> (src_sel != 2'b00) || !hv_ok);

  // R6
  therm_off_chk: assert property (@(posedge clk) disable iff (!vcc_rst_n)
    tsd_flag |=> src_sel == 2'b00);

  // R7
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!vcc_rst_n)
    ctl_start |=> !ctl_start);

  // R7
  start_while_off_chk: assert property (@(posedge clk) disable iff (!vcc_rst_n)
    ctl_start |-> src_sel == 2'b00);

  // R8
  single_start_chk: assert property (@(posedge clk) disable iff (!vcc_rst_n)
    ctl_start |-> !start_seen);

endmodule

bind ssq_supply_keeper ssq_supply_keeper_chk chk_i (
  .clk        (clk),
  .vcc_rst_n  (vcc_rst_n),
  .hv_ok      (hv_ok),
  .tsd_flag   (tsd_flag),
  .src_sel    (src_sel),
  .ctl_start  (ctl_start),
  .stop_entry (stop_entry),
  .restart_evt(restart_evt)
);

// File: tb/ssq_supply_keeper_tb.sv
module ssq_supply_keeper_tb_top;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       vcc_rst_n = 1'b0;
  logic       hv_ok = 1'b1;
  logic       vcc_gt_inh = 1'b0;
  logic       vcc_gt_on = 1'b0;
  logic       vcc_lt_restart = 1'b0;
  logic       tsd_flag = 1'b0;
  logic [1:0] src_sel;
  logic       ctl_start;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ssq_supply_keeper dut_i (
    .clk           (clk),
    .vcc_rst_n     (vcc_rst_n),
    .hv_ok         (hv_ok),
    .vcc_gt_inh    (vcc_gt_inh),
    .vcc_gt_on     (vcc_gt_on),
    .vcc_lt_restart(vcc_lt_restart),
    .tsd_flag      (tsd_flag),
    .src_sel       (src_sel),
    .ctl_start     (ctl_start)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one rising edge, then land on the falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    vcc_rst_n = 1'b0;
    #1;
    check("R1 sel in reset", src_sel, 2'b01);
    check("R1 start in reset", {1'b0, ctl_start}, 2'b00);
    tick();
    vcc_rst_n = 1'b1;
    tick();
    check("R1 sel after release", src_sel, 2'b01);
  endtask

  task automatic t_first_charge();
    vcc_gt_inh = 1'b1; tick();
    check("R3 full level", src_sel, 2'b10);
    vcc_gt_on = 1'b1; tick();
    check("R4 off at first crossing", src_sel, 2'b00);
    check("R7 no start first crossing", {1'b0, ctl_start}, 2'b00);
    vcc_gt_on = 1'b0; tick();
    check("R5 held off before restart", src_sel, 2'b00);
    vcc_lt_restart = 1'b1; tick();
    check("R5 on at restart", src_sel, 2'b10);
    vcc_lt_restart = 1'b0; vcc_gt_on = 1'b1; tick();
    check("R7 start on second crossing", {1'b0, ctl_start}, 2'b01);
    check("R7 sel off with start", src_sel, 2'b00);
    tick();
    check("R7 start one cycle", {1'b0, ctl_start}, 2'b00);
  endtask

  task automatic t_no_restart();
    vcc_gt_on = 1'b0; vcc_lt_restart = 1'b1; tick();
    vcc_lt_restart = 1'b0; vcc_gt_on = 1'b1; tick();
    check("R8 no second start", {1'b0, ctl_start}, 2'b00);
    check("R4 off again", src_sel, 2'b00);
  endtask

  task automatic t_hv_gate();
    vcc_gt_on = 1'b0; hv_ok = 1'b0; vcc_lt_restart = 1'b1; tick();
    check("R9 masked while hv low", src_sel, 2'b00);
    hv_ok = 1'b1; #1;
    check("R9 on same cycle hv back", src_sel, 2'b10);
    vcc_lt_restart = 1'b0; tick();
    hv_ok = 1'b0; #1;
    check("R2 hv low forces off", src_sel, 2'b00);
    hv_ok = 1'b1; vcc_gt_inh = 1'b0; tick();
    check("R3 low level", src_sel, 2'b01);
  endtask

  task automatic t_therm();
    tsd_flag = 1'b1; tick();
    check("R6 off on tsd", src_sel, 2'b00);
    vcc_lt_restart = 1'b1; tick();
    check("R6 held off during tsd", src_sel, 2'b00);
    vcc_lt_restart = 1'b0; tsd_flag = 1'b0; tick();
    check("R6 charge after tsd", src_sel, 2'b01);
    vcc_gt_on = 1'b1; tick();
    check("R6 progress cleared", {1'b0, ctl_start}, 2'b00);
    vcc_gt_on = 1'b0; vcc_lt_restart = 1'b1; tick();
    check("R5 low level restart", src_sel, 2'b01);
    vcc_lt_restart = 1'b0; vcc_gt_on = 1'b1; tick();
    check("R7 start after tsd cycle", {1'b0, ctl_start}, 2'b01);
  endtask

  task automatic t_vcc_reset();
    vcc_gt_on = 1'b0;
    vcc_rst_n = 1'b0; #1;
    check("R1 async reset sel", src_sel, 2'b01);
    check("R1 async reset start", {1'b0, ctl_start}, 2'b00);
    tick();
    vcc_rst_n = 1'b1; tick();
    vcc_gt_on = 1'b1; tick();
    check("R1 no start first crossing", {1'b0, ctl_start}, 2'b00);
  endtask

  initial begin
    tick();
    t_reset();
    t_first_charge();
    t_no_restart();
    t_hv_gate();
    t_therm();
    t_vcc_reset();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule